// File: doc/BRIEF.md
# Serial Register Port for a Real-Time-Clock Seconds Counter

This block is the device end of a three-wire serial register port inside a real-time-clock domain. A host drives an enable line, a serial clock and a data line. The block answers on a data-out line and signals on a ready line when it can take a new transaction. Every transaction names one of eight register slots with a 3-bit index, says whether it reads or writes, and moves one 32-bit word.

Slot 0 is a free-running seconds counter that advances once for each pulse on a one-second tick input. Slot 1 is a 32-bit control word for general-purpose outputs, held in a register and driven out as a plain vector. A write carries its 32-bit payload ahead of the address. The host marks the end of a frame by dropping enable before the final address bit, which is the direction bit. The write commits, or the read word is loaded for shifting out, only when that bit arrives. The three host lines are asynchronous to the system clock and are synchronized before any edge is detected.

Top module: `rtc_serial_regport`

## Requirements
- R1: After reset the ready output is 1, the output control word is 0, data-out is 0 and the seconds counter reads back as 0.
- R2: Data-in is sampled on each rising serial clock edge. The address is 4 bits sent most significant bit first: bits 3..1 are the slot index and bit 0 is the direction (0 = read, 1 = write). The bit clocked while enable is low is the direction bit; all earlier bits are clocked with enable high.
- R3: A write frame is 32 data bits (MSB first), then the 3 index bits, all with enable high, then the direction bit 1 with enable low. The word is stored in the addressed slot on the fourth system clock rising edge after the final serial clock rise reaches the pin.
- R4: Slot 1 holds the output control word; gpo_ctrl_o shows it and changes only on a write to slot 1.
- R5: A read frame is the 3 index bits with enable high, then direction bit 0 with enable low. After each of the 32 following serial clock pulses, ser_dout_o shows the next bit of the word, MSB first, and holds it until the next pulse.
- R6: Slot 0 increments by one, modulo 2^32, on every system clock cycle in which sec_tick_i is 1, and otherwise holds its value.
- R7: A read returns the value the slot had when the direction bit was taken; ticks during the 32 output pulses do not alter the word being shifted out.
- R8: When a write to slot 0 commits in the same cycle as a tick, the written value is stored and the tick is lost.
- R9: ser_ready_o is 1 only while no transaction is in progress and the synchronized enable, clock and data-in lines are all 0; it is 0 while a frame is being sent.
- R10: Slots 2 to 7 read back as 0, and writes to them change neither the seconds counter nor the output control word.
- R11: A frame whose direction bit follows the wrong number of enable-high bits (not 35 for a write, not 3 for a read) is discarded: no slot changes and the port returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_en_i | input | 1 | Host frame enable, asynchronous |
| ser_clk_i | input | 1 | Host serial clock, asynchronous |
| ser_din_i | input | 1 | Host serial data to the block, asynchronous |
| sec_tick_i | input | 1 | One-second tick, one system cycle wide |
| ser_dout_o | output | 1 | Serial read data to the host |
| ser_ready_o | output | 1 | Port idle and able to accept a new frame |
| gpo_ctrl_o | output | 32 | General-purpose output control word (slot 1) |

## Verification
Every host-line change takes two synchronizer cycles and one edge-detect cycle before the shift machine acts on it, so a committed write shows in gpo_ctrl_o on the fourth system edge after the pin change, and each read bit shows on ser_dout_o on the third. The bench holds every serial level for six system cycles and samples outputs on falling system edges well after those points. The tick-collision case is the one check that depends on an exact cycle: the tick is raised on the falling edge just before the fourth rising edge after the final serial clock rise, so it lands in the same cycle as the commit. Checks that nothing changes (unmapped slots, malformed frames) read both registers back through the serial port after the frame.

// File: rtl/rtc_sp_pkg.sv
package rtc_sp_pkg;

    // Register slot numbers decoded by the register file
    localparam int unsigned SLOT_SECONDS = 0;
    localparam int unsigned SLOT_GPO     = 1;

    // Phases of the serial shift machine
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_COLLECT = 2'd1,
        PH_SEND    = 2'd2
    } ph_e;

endpackage

// File: rtl/rtc_sp_sync.sv
module rtc_sp_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : gen_stage
        if (g == 0) begin : gen_first
            assign stage_d[g] = async_i;
        end else begin : gen_next
            assign stage_d[g] = stage_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rtc_sp_regs.sv
module rtc_sp_regs
    import rtc_sp_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [DATA_W-1:0] sec_o,
    output logic [DATA_W-1:0] gpo_o
);

    localparam logic [IDX_W-1:0] IDX_SEC = IDX_W'(SLOT_SECONDS);
    localparam logic [IDX_W-1:0] IDX_GPO = IDX_W'(SLOT_GPO);

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] gpo;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (tick_i) begin
            regs_d.sec = regs_q.sec + DATA_W'(1);
        end
        // A committing write is applied last, so it overrides the tick
        if (wr_en_i) begin
            if (wr_idx_i == IDX_SEC) begin
                regs_d.sec = wr_data_i;
            end else if (wr_idx_i == IDX_GPO) begin
                regs_d.gpo = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        if (rd_idx_i == IDX_SEC) begin
            rd_data_o = regs_q.sec;
        end else if (rd_idx_i == IDX_GPO) begin
            rd_data_o = regs_q.gpo;
        end else begin
            rd_data_o = '0;
        end
    end

    assign sec_o = regs_q.sec;
    assign gpo_o = regs_q.gpo;

endmodule

// File: rtl/rtc_sp_shifter.sv
module rtc_sp_shifter
    import rtc_sp_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s_i,
    input  logic              sclk_s_i,
    input  logic              din_s_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              dout_o,
    output logic              ready_o,
    output logic              idle_o
);

    localparam int unsigned FRAME_W = DATA_W + IDX_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_WRITE = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_READ  = CNT_W'(IDX_W);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(DATA_W - 1);

    typedef struct packed {
        ph_e                phase;
        logic               sclk_prev;
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  out_sr;
        logic               dout;
        logic               ready;
        logic               wr_en;
        logic [IDX_W-1:0]   wr_idx;
        logic [DATA_W-1:0]  wr_data;
    } shf_t;

    shf_t st_d, st_q;
    logic sclk_rise;

    assign sclk_rise = sclk_s_i & ~st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s_i;
        st_d.wr_en     = 1'b0;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (sclk_rise && en_s_i) begin
                    st_d.sr    = {{(FRAME_W-1){1'b0}}, din_s_i};
                    st_d.cnt   = CNT_W'(1);
                    st_d.dout  = 1'b0;
                    st_d.phase = PH_COLLECT;
                end
            end
            PH_COLLECT: begin
                if (sclk_rise) begin
                    if (en_s_i) begin
                        st_d.sr = {st_q.sr[FRAME_W-2:0], din_s_i};
                        if (st_q.cnt != CNT_SAT) begin
                            st_d.cnt = st_q.cnt + CNT_W'(1);
                        end
                    end else if (din_s_i && (st_q.cnt == CNT_WRITE)) begin
                        // direction bit 1: commit the captured word
                        st_d.wr_en   = 1'b1;
                        st_d.wr_idx  = st_q.sr[IDX_W-1:0];
                        st_d.wr_data = st_q.sr[FRAME_W-1:IDX_W];
                        st_d.phase   = PH_IDLE;
                    end else if (!din_s_i && (st_q.cnt == CNT_READ)) begin
                        // direction bit 0: snapshot the slot for shifting
                        st_d.out_sr = rd_data_i;
                        st_d.cnt    = '0;
                        st_d.phase  = PH_SEND;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end
            end
            PH_SEND: begin
                if (sclk_rise) begin
                    st_d.dout   = st_q.out_sr[DATA_W-1];
                    st_d.out_sr = {st_q.out_sr[DATA_W-2:0], 1'b0};
                    st_d.cnt    = st_q.cnt + CNT_W'(1);
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.phase = PH_IDLE;
                    end
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase

        st_d.ready = (st_q.phase == PH_IDLE) && !en_s_i && !sclk_s_i && !din_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.ready <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx_o  = st_q.sr[IDX_W-1:0];
    assign wr_en_o   = st_q.wr_en;
    assign wr_idx_o  = st_q.wr_idx;
    assign wr_data_o = st_q.wr_data;
    assign dout_o    = st_q.dout;
    assign ready_o   = st_q.ready;
    assign idle_o    = (st_q.phase == PH_IDLE);

endmodule

// File: rtl/rtc_serial_regport.sv
module rtc_serial_regport #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned IDX_W       = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en_i,
    input  logic              ser_clk_i,
    input  logic              ser_din_i,
    input  logic              sec_tick_i,
    output logic              ser_dout_o,
    output logic              ser_ready_o,
    output logic [DATA_W-1:0] gpo_ctrl_o
);

    localparam int unsigned LINES = 3;

    logic [LINES-1:0]  lines_s;
    logic              en_s, sclk_s, din_s;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] sec_val;
    logic              phase_idle;

    rtc_sp_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en_i, ser_clk_i, ser_din_i}),
        .sync_o  (lines_s)
    );

    assign en_s   = lines_s[2];
    assign sclk_s = lines_s[1];
    assign din_s  = lines_s[0];

    rtc_sp_shifter #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_s_i    (en_s),
        .sclk_s_i  (sclk_s),
        .din_s_i   (din_s),
        .rd_data_i (rd_data),
        .rd_idx_o  (rd_idx),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .dout_o    (ser_dout_o),
        .ready_o   (ser_ready_o),
        .idle_o    (phase_idle)
    );

    rtc_sp_regs #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (sec_tick_i),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .sec_o     (sec_val),
        .gpo_o     (gpo_ctrl_o)
    );

endmodule

// File: rtl/rtc_sp_checker.sv
module rtc_sp_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] sec,
    input logic [DATA_W-1:0] gpo,
    input logic              ready,
    input logic              phase_idle
);

    logic wr_sec, wr_gpo;
    assign wr_sec = wr_en && (wr_idx == IDX_W'(0));
    assign wr_gpo = wr_en && (wr_idx == IDX_W'(1));

    AST_SEC_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_sec |=> sec == $past(sec) + DATA_W'(1)); // R6

    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !wr_sec |=> $stable(sec)); // R6

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sec |=> sec == $past(wr_data)); // R8

    AST_GPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gpo |=> $stable(gpo)); // R4

    AST_GPO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gpo |=> gpo == $past(wr_data)); // R3

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(phase_idle)); // R9

    AST_COMMIT_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> phase_idle); // R3

endmodule

bind rtc_serial_regport rtc_sp_checker #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (sec_tick_i),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .sec        (sec_val),
    .gpo        (gpo_ctrl_o),
    .ready      (ser_ready_o),
    .phase_idle (phase_idle)
);

// File: tb/rtc_serial_regport_bench.sv
module rtc_serial_regport_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 6;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_en = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        tick = 1'b0;
    logic        dout;
    logic        ready;
    logic [31:0] gpo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_serial_regport u_rtc_serial_regport (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_en_i    (ser_en),
        .ser_clk_i   (ser_clk),
        .ser_din_i   (ser_din),
        .sec_tick_i  (tick),
        .ser_dout_o  (dout),
        .ser_ready_o (ready),
        .gpo_ctrl_o  (gpo)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ser_bit(input logic b);
        @(negedge clk) ser_din = b;
        wait_neg(HOLD);
        ser_clk = 1'b1;
        wait_neg(HOLD);
        ser_clk = 1'b0;
    endtask

    // ndata payload bits (MSB first), 3 index bits, then the direction bit
    task automatic frame(input int ndata, input logic [31:0] data, input logic [2:0] idx,
                         input logic dir, input bit tick_at_commit);
        @(negedge clk) ser_en = 1'b1;
        wait_neg(HOLD);
        for (int i = ndata - 1; i >= 0; i--) ser_bit(data[i]);
        for (int i = 2; i >= 0; i--) ser_bit(idx[i]);
        @(negedge clk) ser_en = 1'b0;
        ser_din = dir;
        wait_neg(HOLD);
        ser_clk = 1'b1;
        if (tick_at_commit) begin
            wait_neg(3);
            tick = 1'b1;
            wait_neg(1);
            tick = 1'b0;
            wait_neg(HOLD - 4);
        end else begin
            wait_neg(HOLD);
        end
        ser_clk = 1'b0;
        ser_din = 1'b0;
        wait_neg(HOLD);
    endtask

    task automatic reg_write(input logic [2:0] idx, input logic [31:0] data, input bit tk);
        frame(32, data, idx, 1'b1, tk);
        wait_neg(4);
    endtask

    task automatic reg_read(input logic [2:0] idx, input int tick_at, output logic [31:0] word);
        frame(0, 32'h0, idx, 1'b0, 1'b0);
        word = '0;
        for (int k = 0; k < 32; k++) begin
            if (k == tick_at || k == tick_at + 1) pulse_tick();
            @(negedge clk) ser_clk = 1'b1;
            wait_neg(HOLD);
            ser_clk = 1'b0;
            wait_neg(HOLD);
            word = {word[30:0], dout};
        end
        wait_neg(4);
    endtask

    task automatic t_reset();
        logic [31:0] w;
        check("R1 ready after reset", {31'b0, ready}, 32'h1);
        check("R1 gpo after reset", gpo, 32'h0);
        check("R1 dout after reset", {31'b0, dout}, 32'h0);
        reg_read(3'd0, -10, w);
        check("R1 seconds after reset", w, 32'h0);
    endtask

    task automatic t_gpo();
        logic [31:0] w;
        reg_write(3'd1, 32'hA5C3_0F1E, 1'b0);
        check("R3 R4 gpo written", gpo, 32'hA5C3_0F1E);
        reg_read(3'd1, -10, w);
        check("R5 gpo read back MSB first", w, 32'hA5C3_0F1E);
        reg_read(3'd4, -10, w);
        check("R2 index bit order (slot 4 is not slot 1)", w, 32'h0);
        check("R5 dout holds last bit", {31'b0, dout}, 32'h0);
    endtask

    task automatic t_ready();
        @(negedge clk) ser_en = 1'b1;
        wait_neg(HOLD);
        check("R9 ready low with enable high", {31'b0, ready}, 32'h0);
        ser_en = 1'b0;
        wait_neg(HOLD);
        check("R9 ready back after enable drop", {31'b0, ready}, 32'h1);
        ser_din = 1'b1;
        wait_neg(HOLD);
        check("R9 ready low with data-in high", {31'b0, ready}, 32'h0);
        ser_din = 1'b0;
        wait_neg(HOLD);
        check("R9 ready after lines idle", {31'b0, ready}, 32'h1);
    endtask

    task automatic t_seconds();
        logic [31:0] w;
        reg_write(3'd0, 32'h0000_1000, 1'b0);
        repeat (3) pulse_tick();
        reg_read(3'd0, -10, w);
        check("R6 seconds after three ticks", w, 32'h0000_1003);
        reg_write(3'd0, 32'hFFFF_FFFF, 1'b0);
        pulse_tick();
        reg_read(3'd0, -10, w);
        check("R6 seconds wrap", w, 32'h0);
    endtask

    task automatic t_snapshot();
        logic [31:0] w;
        reg_write(3'd0, 32'd100, 1'b0);
        reg_read(3'd0, 5, w);
        check("R7 snapshot unaffected by ticks", w, 32'd100);
        reg_read(3'd0, -10, w);
        check("R7 ticks during read still counted", w, 32'd102);
    endtask

    task automatic t_collision();
        logic [31:0] w;
        reg_write(3'd0, 32'h0000_5000, 1'b1);
        reg_read(3'd0, -10, w);
        check("R8 write wins over tick", w, 32'h0000_5000);
    endtask

    task automatic t_unmapped();
        logic [31:0] w;
        reg_write(3'd5, 32'h1234_5678, 1'b0);
        check("R10 slot 5 write leaves gpo", gpo, 32'hA5C3_0F1E);
        reg_read(3'd0, -10, w);
        check("R10 slot 5 write leaves seconds", w, 32'h0000_5000);
        reg_write(3'd6, 32'hDEAD_BEEF, 1'b0);
        reg_read(3'd6, -10, w);
        check("R10 slot 6 reads zero", w, 32'h0);
    endtask

    task automatic t_malformed();
        logic [31:0] w;
        frame(10, 32'h0000_03FF, 3'd1, 1'b1, 1'b0);
        wait_neg(4);
        check("R11 short write discarded", gpo, 32'hA5C3_0F1E);
        check("R11 ready after short write", {31'b0, ready}, 32'h1);
        frame(5, 32'h1F, 3'd1, 1'b0, 1'b0);
        wait_neg(4);
        check("R11 long read discarded, ready", {31'b0, ready}, 32'h1);
        reg_read(3'd1, -10, w);
        check("R11 port usable after bad frames", w, 32'hA5C3_0F1E);
    endtask

    initial begin
        wait_neg(5);
        rst_n = 1'b1;
        wait_neg(3);
        t_reset();
        t_gpo();
        t_ready();
        t_seconds();
        t_snapshot();
        t_collision();
        t_unmapped();
        t_malformed();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule